// File: doc/BRIEF.md
# Compare-Start Synchronous Serial Receiver

This block is a synchronous serial receiver. It runs on the receive clock and takes one data bit from a serial input on every rising edge. It builds those bits into words of a chosen length, from 1 to 32 bits. Each word is shifted in either most significant bit first or least significant bit first. A run of 1 to 16 words makes up one frame.

Reception can start in one of two ways. In free-running mode, word capture begins as soon as the receiver is enabled and runs without pause. In pattern-start mode, the receiver first watches the serial input. It compares the most recent sync-length bits against a primary pattern and starts a frame only when they match. A secondary pattern is watched at the same time. A match on the secondary pattern only raises its own status flag.

Configuration, the received word and the status flags are plain parallel ports. Two read strobes stand in for register reads of the holding register and the status register.

Top module: `serial_rx_cmpstart`

## Requirements
- R1: After reset, `status` and `hold_data` are all zero and the receiver is off. `status` bits 1-4, 6, 7 and 10 always read zero.
- R2: `frame_cfg` holds four fields. Bits [4:0] are the word length minus one. Bit 7 set selects most-significant-first order. Bits [11:8] are the words per frame minus one. Bits [19:16] are the sync length minus one.
- R3: With `start_on_match` low, the first bit captured is the one present at the second rising edge after `rx_en` is raised. Words follow each other with no gap, and a new frame follows the last word of a frame with no gap.
- R4: In most-significant-first order, the first bit of a word lands in bit (length-1) of `hold_data`. Otherwise it lands in bit 0. Bits above the word length read zero.
- R5: At the edge that samples the last bit of a word, `hold_data` takes the word and status bit 0 (ready) is set. A `hold_rd` strobe clears bit 0.
- R6: Status bit 5 (overrun) is set when a word completes while bit 0 is still set and no `hold_rd` arrives in the same cycle. A `stat_rd` strobe clears bit 5 and leaves bit 0 alone. A set in the same cycle as the strobe wins.
- R7: With `start_on_match` high, the receiver hunts. It matches when the last sync-length bits equal the low bits of `cmp0_pat`. The earliest of those bits is compared with bit (sync length-1) and the latest with bit 0. A match sets status bits 8 and 11, and the very next bit is the first data bit.
- R8: In pattern-start mode, after the configured number of words the receiver returns to hunting. It needs a full sync length of new bits before the next match, and it captures no words until that match.
- R9: While hunting, a match against `cmp1_pat` sets status bit 9 only. Hunting continues and no words are captured.
- R10: Lowering `rx_en` stops capture and drops a partly received word. It keeps `hold_data` and the status flags. After re-enabling, word alignment starts afresh.
- R11: A `stat_rd` strobe clears status bits 8, 9 and 11 as well as bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; serial data is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low stops capture |
| sdata | input | 1 | Serial data input |
| frame_cfg | input | 20 | Word length, bit order, words per frame and sync length fields |
| start_on_match | input | 1 | 0: free-running start, 1: start on primary pattern match |
| cmp0_pat | input | SYNC_MAX | Primary start pattern |
| cmp1_pat | input | SYNC_MAX | Secondary pattern, flag only |
| hold_rd | input | 1 | Strobe: holding register read |
| stat_rd | input | 1 | Strobe: status register read |
| hold_data | output | MAX_DW | Last completed word |
| status | output | 12 | Status flags |

## Verification
The bench builds the block with its default parameters: 32-bit maximum words, 16 words per frame and a 16-bit sync window. These settings let it sweep every word length from 1 to 32 in both bit orders, and every sync length from 1 to 16. Each sweep case uses a pattern whose top bit is set, placed after a run of zeros, so that the match can only fall on the final pattern bit. Further runs cover frame wrap-around in free-running mode, return to hunting after a short frame, overrun, the secondary pattern and disabling in the middle of a word.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [1:0] {
      RX_OFF  = 2'd0,
      RX_HUNT = 2'd1,
      RX_DATA = 2'd2
   } rx_state_t;

   // frame_cfg field placement
   localparam int CFG_W        = 20;
   localparam int CFG_DLEN_LSB = 0;
   localparam int CFG_MSBF_BIT = 7;
   localparam int CFG_WCNT_LSB = 8;
   localparam int CFG_SLEN_LSB = 16;

   // status bit placement
   localparam int STAT_W    = 12;
   localparam int ST_RDY    = 0;
   localparam int ST_OVR    = 5;
   localparam int ST_CMP0   = 8;
   localparam int ST_SYNC   = 11;

endpackage

// File: rtl/srx_pattern_match.sv
module srx_pattern_match #(
   parameter int SYNC_MAX = 16,
   parameter int NUM_PAT  = 2,
   localparam int SLW = $clog2(SYNC_MAX),
   localparam int CW  = $clog2(SYNC_MAX + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              hunt,
   input  logic                              sdata,
   input  logic [SLW-1:0]                    slen_m1,
   input  logic [NUM_PAT-1:0][SYNC_MAX-1:0]  pats,
   output logic [NUM_PAT-1:0]                hit
);

   logic [SYNC_MAX-1:0] hist_q, hist_nx, mask;
   logic [CW-1:0]       cnt_q, cnt_nx;
   logic                full;

   // newest bit enters at bit 0
   assign hist_nx = {hist_q[SYNC_MAX-2:0], sdata};
   assign cnt_nx  = (cnt_q == CW'(SYNC_MAX)) ? cnt_q : cnt_q + 1'b1;
   assign full    = cnt_nx > CW'(slen_m1);

   for (genvar i = 0; i < SYNC_MAX; i++) begin : g_mask
      assign mask[i] = (SLW'(i) <= slen_m1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         cnt_q  <= '0;
      end else if (hunt) begin
         hist_q <= hist_nx;
         cnt_q  <= cnt_nx;
      end else begin
         // leaving the hunt forgets the bit count: fresh bits are required
         cnt_q  <= '0;
      end
   end

   for (genvar p = 0; p < NUM_PAT; p++) begin : g_cmp
      assign hit[p] = hunt && full && (((hist_nx ^ pats[p]) & mask) == '0);
   end

   // R8: no match may come from fewer bits than the sync length
   a_r8_enough_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |-> (cnt_q >= CW'(slen_m1)));

endmodule

// File: rtl/srx_word_asm.sv
module srx_word_asm #(
   parameter int MAX_DW    = 32,
   parameter int MAX_WORDS = 16,
   localparam int DLW = $clog2(MAX_DW),
   localparam int WCW = $clog2(MAX_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sdata,
   input  logic              msb_first,
   input  logic [DLW-1:0]    dlen_m1,
   input  logic [WCW-1:0]    nwords_m1,
   output logic              word_done,
   output logic              frame_done,
   output logic [MAX_DW-1:0] word
);

   logic [DLW-1:0]    bit_q;
   logic [WCW-1:0]    wcnt_q;
   logic [MAX_DW-1:0] sh_q, base;

   always_comb begin
      base = (bit_q == '0) ? '0 : sh_q;
      if (msb_first) begin
         word = {base[MAX_DW-2:0], sdata};
      end else begin
         word = base;
         for (int i = 0; i < MAX_DW; i++) begin
            if (DLW'(i) == bit_q) word[i] = sdata;
         end
      end
   end

   assign word_done  = active && (bit_q == dlen_m1);
   assign frame_done = word_done && (wcnt_q == nwords_m1);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         bit_q  <= '0;
         wcnt_q <= '0;
         sh_q   <= '0;
      end else begin
         sh_q  <= word;
         bit_q <= word_done ? '0 : bit_q + 1'b1;
         if (word_done) wcnt_q <= frame_done ? '0 : wcnt_q + 1'b1;
      end
   end

   // R3: a completed frame restarts word counting
   a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (wcnt_q == '0) && (bit_q == '0));

endmodule

// File: rtl/srx_flags.sv
module srx_flags
   import srx_pkg::*;
#(
   parameter int MAX_DW  = 32,
   parameter int NUM_PAT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_done,
   input  logic [MAX_DW-1:0]  word,
   input  logic               hold_rd,
   input  logic               stat_rd,
   input  logic [NUM_PAT-1:0] pat_hit,
   input  logic               start_hit,
   output logic [MAX_DW-1:0]  hold_data,
   output logic [STAT_W-1:0]  status
);

   logic               rdy_q, ovr_q, sync_q;
   logic [NUM_PAT-1:0] cmp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_data <= '0;
         rdy_q     <= 1'b0;
         ovr_q     <= 1'b0;
         sync_q    <= 1'b0;
      end else begin
         if (word_done) hold_data <= word;
         rdy_q  <= word_done || (rdy_q && !hold_rd);
         ovr_q  <= (word_done && rdy_q && !hold_rd) || (ovr_q && !stat_rd);
         sync_q <= start_hit || (sync_q && !stat_rd);
      end
   end

   for (genvar p = 0; p < NUM_PAT; p++) begin : g_cmpflag
      always_ff @(posedge clk) begin
         if (!rst_n) cmp_q[p] <= 1'b0;
         else        cmp_q[p] <= pat_hit[p] || (cmp_q[p] && !stat_rd);
      end
   end

   always_comb begin
      status = '0;
      status[ST_RDY]  = rdy_q;
      status[ST_OVR]  = ovr_q;
      status[ST_SYNC] = sync_q;
      for (int p = 0; p < NUM_PAT; p++) status[ST_CMP0 + p] = cmp_q[p];
   end

   // R6: overrun only rises over an unread word
   a_r6_ovr_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(rdy_q));
   // R5: reading the holding register clears ready
   a_r5_rdy_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_rd && !word_done) |=> !rdy_q);
   // R11: a status read clears the sticky event flags
   a_r11_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !word_done && !(|pat_hit)) |=> (!ovr_q && !sync_q && (cmp_q == '0)));
   // R7: sync is always accompanied by a primary match
   a_r7_sync_with_cmp0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_q) |-> cmp_q[0]);

endmodule

// File: rtl/serial_rx_cmpstart.sv
module serial_rx_cmpstart
   import srx_pkg::*;
#(
   parameter int MAX_DW    = 32,
   parameter int MAX_WORDS = 16,
   parameter int SYNC_MAX  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_en,
   input  logic                sdata,
   input  logic [CFG_W-1:0]    frame_cfg,
   input  logic                start_on_match,
   input  logic [SYNC_MAX-1:0] cmp0_pat,
   input  logic [SYNC_MAX-1:0] cmp1_pat,
   input  logic                hold_rd,
   input  logic                stat_rd,
   output logic [MAX_DW-1:0]   hold_data,
   output logic [STAT_W-1:0]   status
);

   localparam int DLW     = $clog2(MAX_DW);
   localparam int WCW     = $clog2(MAX_WORDS);
   localparam int SLW     = $clog2(SYNC_MAX);
   localparam int NUM_PAT = 2;

   // elaboration checks: fields must fit their configuration slots
   if (MAX_DW < 2 || MAX_DW > 32 || (1 << DLW) != MAX_DW) begin : g_bad_dw
      $error("MAX_DW must be a power of two in 2..32");
   end
   if (MAX_WORDS < 2 || MAX_WORDS > 16 || (1 << WCW) != MAX_WORDS) begin : g_bad_words
      $error("MAX_WORDS must be a power of two in 2..16");
   end
   if (SYNC_MAX < 2 || SYNC_MAX > 16 || (1 << SLW) != SYNC_MAX) begin : g_bad_sync
      $error("SYNC_MAX must be a power of two in 2..16");
   end

   logic [DLW-1:0] dlen_m1;
   logic [WCW-1:0] nwords_m1;
   logic [SLW-1:0] slen_m1;
   logic           msb_first;
   logic           cfg_unused;

   assign dlen_m1    = frame_cfg[CFG_DLEN_LSB +: DLW];
   assign nwords_m1  = frame_cfg[CFG_WCNT_LSB +: WCW];
   assign slen_m1    = frame_cfg[CFG_SLEN_LSB +: SLW];
   assign msb_first  = frame_cfg[CFG_MSBF_BIT];
   assign cfg_unused = ^frame_cfg;

   rx_state_t          state_q, state_nx;
   logic               hunt, active, start_hit;
   logic               word_done, frame_done;
   logic [MAX_DW-1:0]  word;
   logic [NUM_PAT-1:0] pat_hit;
   logic [NUM_PAT-1:0][SYNC_MAX-1:0] pats;

   assign pats      = {cmp1_pat, cmp0_pat};
   assign hunt      = rx_en && (state_q == RX_HUNT);
   assign active    = rx_en && (state_q == RX_DATA);
   assign start_hit = pat_hit[0];

   always_comb begin
      state_nx = state_q;
      if (!rx_en) begin
         state_nx = RX_OFF;
      end else begin
         unique case (state_q)
            RX_OFF:  state_nx = start_on_match ? RX_HUNT : RX_DATA;
            RX_HUNT: if (start_hit) state_nx = RX_DATA;
            RX_DATA: if (frame_done && start_on_match) state_nx = RX_HUNT;
            default: state_nx = RX_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= RX_OFF;
      else        state_q <= state_nx;
   end

   srx_pattern_match #(.SYNC_MAX(SYNC_MAX), .NUM_PAT(NUM_PAT)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .hunt    (hunt),
      .sdata   (sdata),
      .slen_m1 (slen_m1),
      .pats    (pats),
      .hit     (pat_hit)
   );

   srx_word_asm #(.MAX_DW(MAX_DW), .MAX_WORDS(MAX_WORDS)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .sdata      (sdata),
      .msb_first  (msb_first),
      .dlen_m1    (dlen_m1),
      .nwords_m1  (nwords_m1),
      .word_done  (word_done),
      .frame_done (frame_done),
      .word       (word)
   );

   srx_flags #(.MAX_DW(MAX_DW), .NUM_PAT(NUM_PAT)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_done (word_done),
      .word      (word),
      .hold_rd   (hold_rd),
      .stat_rd   (stat_rd),
      .pat_hit   (pat_hit),
      .start_hit (start_hit),
      .hold_data (hold_data),
      .status    (status)
   );

   // R10: a low enable returns the receiver to off
   a_r10_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (state_q == RX_OFF));
   // R8: a finished frame in pattern-start mode goes back to hunting
   a_r8_frame_hunt: assert property (@(posedge clk) disable iff (!rst_n)
      (active && frame_done && start_on_match) |=> (state_q == RX_HUNT));
   // R3: free-running mode never hunts
   a_r3_no_hunt: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_on_match && $past(!start_on_match) && state_q == RX_OFF) |=> (state_q != RX_HUNT));

endmodule

// File: tb/serial_rx_cmpstart_bench.sv
module serial_rx_cmpstart_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic        sdata = 1'b0;
   logic [19:0] frame_cfg = '0;
   logic        start_on_match = 1'b0;
   logic [15:0] cmp0_pat = '0;
   logic [15:0] cmp1_pat = '0;
   logic        hold_rd = 1'b0;
   logic        stat_rd = 1'b0;
   logic [31:0] hold_data;
   logic [11:0] status;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   serial_rx_cmpstart u_serial_rx_cmpstart (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sdata(sdata),
      .frame_cfg(frame_cfg), .start_on_match(start_on_match),
      .cmp0_pat(cmp0_pat), .cmp1_pat(cmp1_pat),
      .hold_rd(hold_rd), .stat_rd(stat_rd),
      .hold_data(hold_data), .status(status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [19:0] mk_cfg(input int dlen, input int nw, input int slen, input bit msbf);
      logic [19:0] c = '0;
      c[4:0]   = 5'(dlen - 1);
      c[7]     = msbf;
      c[11:8]  = 4'(nw - 1);
      c[19:16] = 4'(slen - 1);
      return c;
   endfunction

   function automatic logic [31:0] lowmask(input int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
   endfunction

   task automatic send_bit(input logic b);
      @(negedge clk); sdata = b;
      @(posedge clk); #1;
   endtask

   task automatic send_word(input logic [31:0] v, input int n, input bit msbf);
      for (int i = 0; i < n; i++) send_bit(msbf ? v[n-1-i] : v[i]);
   endtask

   task automatic go_on();
      @(negedge clk); rx_en = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic go_off();
      @(negedge clk); rx_en = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic pulse_hold();
      @(negedge clk); hold_rd = 1'b1;
      @(negedge clk); hold_rd = 1'b0;
      #1;
   endtask

   task automatic pulse_stat();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
      #1;
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, p;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 status", 32'(status), 32'h0);
      chk("R1 hold", hold_data, 32'h0);

      // R2 R3 R4 R5: every word length, both orders, free-running mode
      for (int d = 1; d <= 32; d++) begin
         for (int m = 0; m < 2; m++) begin
            v = (32'hA5C3_1E97 ^ (32'(d) * 32'h0101_0301 + 32'(m))) & lowmask(d);
            frame_cfg = mk_cfg(d, 16, 4, m[0]);
            start_on_match = 1'b0;
            go_on();
            send_word(v, d, m[0]);
            chk("R4 word value", hold_data, v);
            chk("R5 ready set", 32'(status[0]), 32'h1);
            go_off();
            pulse_hold();
            chk("R5 ready cleared", 32'(status[0]), 32'h0);
         end
      end

      // R3: back-to-back words across a frame boundary (3 words per frame)
      frame_cfg = mk_cfg(4, 3, 4, 1'b1);
      go_on();
      send_word(32'h9, 4, 1'b1); chk("R3 word0", hold_data, 32'h9);
      send_word(32'h3, 4, 1'b1); chk("R3 word1", hold_data, 32'h3);
      send_word(32'hC, 4, 1'b1); chk("R3 word2", hold_data, 32'hC);
      send_word(32'h6, 4, 1'b1); chk("R3 word after wrap", hold_data, 32'h6);
      // R6: unread words raised overrun
      chk("R6 overrun set", 32'(status[5]), 32'h1);
      go_off();
      pulse_stat();
      chk("R6 overrun cleared", 32'(status[5]), 32'h0);
      chk("R6 ready kept", 32'(status[0]), 32'h1);
      pulse_hold();
      chk("R1 reserved bits zero", 32'(status & 12'h4DE), 32'h0);

      // R10: disable mid-word keeps flags and restarts alignment
      frame_cfg = mk_cfg(8, 1, 4, 1'b1);
      go_on();
      send_word(32'h5A, 8, 1'b1);
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      go_off();
      chk("R10 hold kept", hold_data, 32'h5A);
      chk("R10 ready kept", 32'(status[0]), 32'h1);
      pulse_hold();
      go_on();
      send_word(32'hC3, 8, 1'b1);
      chk("R10 realigned word", hold_data, 32'hC3);
      go_off();
      pulse_hold();

      // R7 R11: every sync length in pattern-start mode
      start_on_match = 1'b1;
      cmp1_pat = 16'h0;
      for (int s = 1; s <= 16; s++) begin
         p = ((32'(s) * 32'h2B5) | (32'd1 << (s - 1))) & lowmask(s);
         cmp0_pat = p[15:0];
         cmp1_pat = ~p[15:0] | 16'h8000;
         frame_cfg = mk_cfg(8, 1, s, 1'b1);
         go_on();
         for (int i = 0; i < s; i++) send_bit(1'b0);
         chk("R7 no capture before match", 32'(status[0]), 32'h0);
         send_word(p, s, 1'b1);
         v = (32'(s) * 32'd29) & 32'hFF;
         send_word(v, 8, 1'b1);
         chk("R7 data after sync", hold_data, v);
         chk("R7 cmp0 flag", 32'(status[8]), 32'h1);
         chk("R7 sync flag", 32'(status[11]), 32'h1);
         go_off();
         pulse_stat();
         chk("R11 flags cleared", 32'(status & 12'hB20), 32'h0);
         pulse_hold();
      end

      // R9: secondary pattern flags only
      frame_cfg = mk_cfg(8, 1, 4, 1'b1);
      cmp0_pat = 16'hF;
      cmp1_pat = 16'h9;
      go_on();
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      send_word(32'h9, 4, 1'b1);
      chk("R9 cmp1 flag", 32'(status[9]), 32'h1);
      chk("R9 no cmp0", 32'(status[8]), 32'h0);
      chk("R9 no sync", 32'(status[11]), 32'h0);
      for (int i = 0; i < 8; i++) send_bit(1'b0);
      chk("R9 still hunting", 32'(status[0]), 32'h0);
      go_off();
      pulse_stat();

      // R8: two-word frame, then back to hunting
      frame_cfg = mk_cfg(8, 2, 4, 1'b0);
      cmp0_pat = 16'hB;
      cmp1_pat = 16'h6;
      go_on();
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      send_word(32'hB, 4, 1'b1);
      send_word(32'h3D, 8, 1'b0);
      chk("R8 frame word0", hold_data, 32'h3D);
      send_word(32'hE2, 8, 1'b0);
      chk("R8 frame word1", hold_data, 32'hE2);
      @(negedge clk); sdata = 1'b0;
      pulse_hold();
      pulse_stat();
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      chk("R8 no capture while hunting", 32'(status[0]), 32'h0);
      chk("R8 no rematch", 32'(status[8]), 32'h0);
      send_word(32'hB, 4, 1'b1);
      send_word(32'h71, 8, 1'b0);
      chk("R8 next frame word", hold_data, 32'h71);
      chk("R8 rematch flag", 32'(status[8]), 32'h1);
      go_off();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule